// File: doc/BRIEF.md
# Masked-Address GPIO with Per-Pin Interrupts

This block is an eight-pin general-purpose I/O port on a simple memory-mapped register bus with byte-wide data. Each pin has its own direction bit. Software reaches single pins in the data window without a read-modify-write, because the address of each data access carries a per-pin bit mask.

Every pin has an interrupt detector. Three independent configuration bits select how it fires: level or edge, both edges, and polarity. Edge events stay latched until software clears them by writing ones. Level events follow the pin for as long as the level lasts. One combined interrupt line reports every enabled pending pin.

Pad inputs are synchronised with two flops before any use. A separate mode register is plain storage and has no effect on the pins.

Top module: `gpio_mask_irq`

## Requirements
- R1: After reset every register reads zero. `pad_oe_o`, `pad_out_o` and `irq_o` are all zero.
- R2: A write to any offset below 0x400 uses address bits [9:2] as a mask, where bit n+2 selects pin n. Only the output bits whose mask bit is set take the write data; the other output bits keep their value.
- R3: A read below 0x400 returns each pin's value ANDed with the address mask. An output pin (direction 1) reads back its output register. An input pin reads back its synchronised pad level.
- R4: Offset 0x400 holds the direction byte, where 1 means output. `pad_oe_o` equals this register.
- R5: Pad inputs pass through two flops. An edge is a difference between the synchronised value and its value one cycle earlier. A pad change shows in the status no later than four clock cycles after it occurs.
- R6: With sense bit (0x404) = 0 and both-edges bit (0x408) = 0, the polarity bit (0x40C) selects the edge: 1 means rising, 0 means falling. The opposite edge does nothing. A detected edge stays in raw status until it is cleared.
- R7: With sense = 0 and both-edges = 1, either transition sets the status and the polarity bit is ignored.
- R8: With sense = 1, the raw status equals the synchronised pin level when polarity = 1, and the inverted level when polarity = 0. A clear write does not remove it.
- R9: Offset 0x41C is write-only. Writing 1 to a bit clears that pin's latched edge status, and writing 0 has no effect. If a clear and a new edge land in the same cycle, the status stays set.
- R10: Offset 0x410 holds the enable byte. Raw status at 0x414 is read-only, so writes there change nothing. Masked status at 0x418 equals raw AND enable. `irq_o` is the OR of the masked bits.
- R11: Offset 0x420 holds a read/write byte with no effect on any pad output.
- R12: Reads of offsets outside the data window and the listed registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as a read |
| pad_in_i | input | 8 | Asynchronous pad levels |
| pad_out_o | output | 8 | Output data to the pads |
| pad_oe_o | output | 8 | Output enables to the pads |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that a bus access lasts exactly one cycle with `sel_i` high. They also assume that `wdata_i` and `addr_i` are valid whenever `sel_i` is high. The latch property assumes that sense bits change only through bus writes.

The stimulus drives every bus field and every pad level at the falling clock edge, so the inputs never move near a sampling edge. Before any status is read it waits at least four cycles after each pad change. The clear-versus-edge test uses exact cycle counting from the pad change so that both events land on the same edge.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned PIN_N  = 8;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_EN    = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 12'h420;

  typedef struct packed {
    logic sense;
    logic both;
    logic pol;
  } det_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_prev_o <= '0;
    else q_prev_o <= stg[STAGES-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_mask_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cur_i,
  input  logic     prev_i,
  input  det_cfg_t cfg_i,
  input  logic     clr_i,
  output logic     raw_o
);
  logic rise, fall, hit, level, latch_q;

  assign rise  = cur_i & ~prev_i;
  assign fall  = ~cur_i & prev_i;
  assign hit   = cfg_i.both ? (rise | fall) : (cfg_i.pol ? rise : fall);
  assign level = cfg_i.pol ? cur_i : ~cur_i;

  // new edge beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b0;
    else latch_q <= ~cfg_i.sense & (hit | (latch_q & ~clr_i));
  end

  assign raw_o = cfg_i.sense ? level : latch_q;
endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq
  import gpio_mask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_N-1:0]  wdata_i,
  output logic [PIN_N-1:0]  rdata_o,
  input  logic [PIN_N-1:0]  pad_in_i,
  output logic [PIN_N-1:0]  pad_out_o,
  output logic [PIN_N-1:0]  pad_oe_o,
  output logic              irq_o
);
  localparam int unsigned MSK_LO = 2;
  localparam int unsigned MSK_HI = MSK_LO + PIN_N - 1;

  logic [PIN_N-1:0] dout_q, dir_q, sense_q, both_q, pol_q, en_q, mode_q;
  logic [PIN_N-1:0] pin_cur, pin_prev, raw_stat, clr_vec, acc_mask, pin_val;
  logic             in_dwin, wr_acc, rd_acc;

  assign in_dwin  = (addr_i[ADDR_W-1:MSK_HI+1] == '0);
  assign acc_mask = addr_i[MSK_HI:MSK_LO];
  assign wr_acc   = sel_i & wr_i;
  assign rd_acc   = sel_i & ~wr_i;

  gpio_sync #(.W(PIN_N), .STAGES(2)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (pad_in_i),
    .q_o      (pin_cur),
    .q_prev_o (pin_prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      mode_q  <= '0;
    end else if (wr_acc) begin
      if (in_dwin) dout_q <= (dout_q & ~acc_mask) | (wdata_i & acc_mask);
      else begin
        case (addr_i)
          OFS_DIR:   dir_q   <= wdata_i;
          OFS_SENSE: sense_q <= wdata_i;
          OFS_BOTH:  both_q  <= wdata_i;
          OFS_POL:   pol_q   <= wdata_i;
          OFS_EN:    en_q    <= wdata_i;
          OFS_MODE:  mode_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign clr_vec = (wr_acc && addr_i == OFS_CLR) ? wdata_i : '0;

  for (genvar p = 0; p < PIN_N; p++) begin : g_det
    det_cfg_t cfg;
    assign cfg = '{sense: sense_q[p], both: both_q[p], pol: pol_q[p]};
    gpio_irq_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (pin_cur[p]),
      .prev_i (pin_prev[p]),
      .cfg_i  (cfg),
      .clr_i  (clr_vec[p]),
      .raw_o  (raw_stat[p])
    );
  end

  assign pin_val = (dir_q & dout_q) | (~dir_q & pin_cur);

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (in_dwin) rdata_o = pin_val & acc_mask;
      else begin
        case (addr_i)
          OFS_DIR:   rdata_o = dir_q;
          OFS_SENSE: rdata_o = sense_q;
          OFS_BOTH:  rdata_o = both_q;
          OFS_POL:   rdata_o = pol_q;
          OFS_EN:    rdata_o = en_q;
          OFS_RAW:   rdata_o = raw_stat;
          OFS_MSK:   rdata_o = raw_stat & en_q;
          OFS_MODE:  rdata_o = mode_q;
          default:   rdata_o = '0;
        endcase
      end
    end
  end

  assign pad_out_o = dout_q;
  assign pad_oe_o  = dir_q;
  assign irq_o     = |(raw_stat & en_q);
endmodule

// File: rtl/gpio_mask_irq_chk.sv
module gpio_mask_irq_chk
  import gpio_mask_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PIN_N-1:0]  wdata_i,
  input logic [PIN_N-1:0]  rdata_o,
  input logic [PIN_N-1:0]  pad_out_o,
  input logic [PIN_N-1:0]  pad_oe_o,
  input logic              irq_o,
  input logic [PIN_N-1:0]  raw_i,
  input logic [PIN_N-1:0]  en_i,
  input logic [PIN_N-1:0]  sense_i
);
  logic dwin_wr, clr_wr;
  logic [PIN_N-1:0] amask;
  assign dwin_wr = sel_i && wr_i && (addr_i < OFS_DIR);
  assign clr_wr  = sel_i && wr_i && (addr_i == OFS_CLR);
  assign amask   = addr_i[PIN_N+1:2];

  assert_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == OFS_DIR) |=> (pad_oe_o == $past(wdata_i)));

  assert_dwin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwin_wr |=> (pad_out_o == (($past(pad_out_o) & ~$past(amask)) | ($past(wdata_i) & $past(amask)))));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

  assert_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((raw_i & en_i) != '0));

  assert_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> (($past(raw_i) & ~$past(sense_i) & ~sense_i & ~raw_i) == '0));

  assert_unmapped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i > OFS_MODE) |-> (rdata_o == '0));
endmodule

bind gpio_mask_irq gpio_mask_irq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .irq_o     (irq_o),
  .raw_i     (raw_stat),
  .en_i      (en_q),
  .sense_i   (sense_q)
);

// File: tb/sim_gpio_mask_irq.sv
`timescale 1ns/1ps
module sim_gpio_mask_irq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq;
  int          total = 0, bad = 0;
  int          cyc = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] wd;
    logic [7:0] expv;
  } vec_t;
  localparam vec_t TBL [6] = '{
    '{8'hFF, 8'hA5, 8'hA5}, '{8'h0F, 8'h00, 8'hA0}, '{8'hF0, 8'h3C, 8'h30},
    '{8'h81, 8'hFF, 8'hB1}, '{8'h00, 8'hFF, 8'hB1}, '{8'h42, 8'h42, 8'hF3}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, expv);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] expv);
    logic [7:0] v;
    bus_rd(a, v);
    check(tag, v, expv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog got=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk("R1 dir", 12'h400, 8'h00);
    rd_chk("R1 en", 12'h410, 8'h00);

    // R4 direction
    bus_wr(12'h400, 8'hFF);
    check("R4 pad_oe", pad_oe, 8'hFF);
    rd_chk("R4 dir read", 12'h400, 8'hFF);

    // R2/R3 vector table walk
    for (int i = 0; i < 6; i++) begin
      bus_wr({2'b00, TBL[i].mask, 2'b00}, TBL[i].wd);
      check("R2 masked write", pad_out, TBL[i].expv);
      rd_chk("R3 full read", 12'h3FC, TBL[i].expv);
    end
    rd_chk("R3 partial mask", 12'h03C, 8'h03);

    // R3/R5 mixed direction
    bus_wr(12'h400, 8'h0F);
    pad_in = 8'hA0;
    idle(4);
    rd_chk("R3 mixed read", 12'h3FC, 8'hA3);
    rd_chk("R3 mask C0", 12'h300, 8'h80);

    // R11 mode register
    bus_wr(12'h420, 8'h5A);
    rd_chk("R11 mode read", 12'h420, 8'h5A);
    check("R11 pad_out", pad_out, 8'hF3);
    check("R11 pad_oe", pad_oe, 8'h0F);

    // R12 unmapped, R10 raw read-only
    rd_chk("R12 unmapped 424", 12'h424, 8'h00);
    rd_chk("R12 unmapped 7FC", 12'h7FC, 8'h00);
    bus_wr(12'h414, 8'hFF);
    rd_chk("R10 raw read-only", 12'h414, 8'h00);

    bus_wr(12'h400, 8'h00);
    pad_in = 8'h00;
    idle(4);
    bus_wr(12'h41C, 8'hFF);
    rd_chk("R9 clear all", 12'h414, 8'h00);

    // R6 rising on pin0
    bus_wr(12'h40C, 8'h01);
    bus_wr(12'h410, 8'h01);
    pad_in = 8'h01; idle(4);
    rd_chk("R6 rise raw", 12'h414, 8'h01);
    rd_chk("R10 masked", 12'h418, 8'h01);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    pad_in = 8'h00; idle(4);
    rd_chk("R6 stays latched", 12'h414, 8'h01);
    bus_wr(12'h41C, 8'h00);
    rd_chk("R9 zero no effect", 12'h414, 8'h01);
    bus_wr(12'h41C, 8'h01);
    rd_chk("R9 clear pin0", 12'h414, 8'h00);
    check("R10 irq low", {7'b0, irq}, 8'h00);

    // R6 falling on pin1
    bus_wr(12'h410, 8'h03);
    pad_in = 8'h02; idle(4);
    rd_chk("R6 rise ignored", 12'h414, 8'h00);
    pad_in = 8'h00; idle(4);
    rd_chk("R6 fall raw", 12'h414, 8'h02);
    bus_wr(12'h41C, 8'hFF);

    // R7 both edges on pin2, polarity set to rising but ignored
    bus_wr(12'h408, 8'h04);
    bus_wr(12'h40C, 8'h05);
    pad_in = 8'h04; idle(4);
    rd_chk("R7 rise", 12'h414, 8'h04);
    rd_chk("R10 masked excl", 12'h418, 8'h00);
    check("R10 irq masked", {7'b0, irq}, 8'h00);
    bus_wr(12'h41C, 8'hFF);
    pad_in = 8'h00; idle(4);
    rd_chk("R7 fall", 12'h414, 8'h04);
    bus_wr(12'h41C, 8'hFF);
    pad_in = 8'h04; idle(4);
    bus_wr(12'h41C, 8'hFF);

    // R8 level high on pin3
    bus_wr(12'h404, 8'h08);
    bus_wr(12'h40C, 8'h09);
    pad_in = 8'h0C; idle(4);
    rd_chk("R8 level high", 12'h414, 8'h08);
    bus_wr(12'h41C, 8'hFF);
    rd_chk("R8 not clearable", 12'h414, 8'h08);
    pad_in = 8'h04; idle(4);
    rd_chk("R8 level gone", 12'h414, 8'h00);

    // R8 level low on pin4
    bus_wr(12'h404, 8'h18);
    rd_chk("R8 level low", 12'h414, 8'h10);
    bus_wr(12'h410, 8'h10);
    check("R10 irq level", {7'b0, irq}, 8'h01);
    pad_in = 8'h14; idle(4);
    rd_chk("R8 low released", 12'h414, 8'h00);
    check("R10 irq off", {7'b0, irq}, 8'h00);

    // R9 clear and edge in the same cycle on pin0
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h410, 8'h01);
    pad_in = 8'h15; idle(4);
    rd_chk("R6 pin0 latched", 12'h414, 8'h01);
    pad_in = 8'h14; idle(4);
    pad_in = 8'h15;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_wr(12'h41C, 8'h01);
    rd_chk("R9 edge wins", 12'h414, 8'h01);
    bus_wr(12'h41C, 8'h01);
    rd_chk("R9 cleared", 12'h414, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule